// File: doc/BRIEF.md
# Set/Clear Register Interrupt Controller

This block collects 32 level-sensitive interrupt sources and turns them into two request lines and one wakeup line. Software programs it through a small word-addressed register port. Each control field is a 32-bit plane with one bit per source. A plane changes only through a write-one-to-set address and a write-one-to-clear address, so no read-modify-write sequence is needed and concurrent agents cannot lose each other's updates.

Three configuration planes together form a 3-bit trigger code for each source. The mask plane gates the source onto a request line. The routing plane chooses which of the two request lines the source drives. The wakeup plane lets the source raise the wakeup line whether or not it is masked. Two status words show which unmasked, detected sources are pending on each request line.

Source inputs are synchronized by two flops before detection. Each output is a registered OR of its status word.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset every plane reads 0, so all sources are disabled, masked and routed to request line 1, and `req0_o`, `req1_o`, `wake_o` and `rd_data` are 0.
- R2: Plane p (0 cfg0, 1 cfg1, 2 cfg2, 3 mask, 4 wakeup, 5 routing) has its set address at 2p and its clear address at 2p+1. A write to the set address ORs `wr_data` into the plane. A write to the clear address removes the 1-bits of `wr_data` from the plane. 0-bits leave the plane unchanged. A read of either address returns the plane.
- R3: The trigger code {cfg2,cfg1,cfg0} = 3'b101 detects a source while its synchronized input is 1.
- R4: The trigger code 3'b110 detects a source while its synchronized input is 0.
- R5: Every other trigger code, 3'b000 included, never detects the source, whatever the input level.
- R6: A routing bit of 1 sends the source to request line 0. A routing bit of 0 sends it to request line 1.
- R7: A source reaches a status word or a request line only while its mask bit is 1.
- R8: `wake_o` is 1 when any detected source has its wakeup bit set, independent of the mask.
- R9: A read of address 12 returns status 0 (detected, masked-in and routed to line 0). A read of address 13 returns status 1 (the same for line 1). A read of address 14 returns the raw detected word. All other addresses read as 0.
- R10: `req0_o` and `req1_o` are the OR of their status words and `wake_o` is the OR of detected-and-wakeup. Each is registered. An input change shows at the outputs on the third rising edge after it. A plane write shows on the second rising edge after it.
- R11: Detection does not latch. A status bit falls once its synchronized input leaves the active level.
- R12: `rd_data` is loaded on the edge that samples `rd_en` and holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Asynchronous interrupt source levels |
| addr | input | 5 | Register word address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, one bit per source |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wakeup line |

## Verification
The sources are driven with patterns that put each trigger code at its active level and then at its inactive level. Low-active, high-active and disabled codes are mixed in a single word, which separates the two polarities from each other and from the disabled codes (111, 010 and 000). Routing bits alternate across neighbouring sources, so a swapped request line shows at once. A masked source that is still wakeup-enabled separates the mask path from the wakeup path. An input edge is timed on single cycles to pin the synchronizer and output register latency. The bench's model is compared with every output on every clock, which also catches read data that changes without a read.

// File: rtl/irq_setclr_pkg.sv
package irq_setclr_pkg;
  localparam int NPLANE   = 6;
  localparam int PL_CFG0  = 0;
  localparam int PL_CFG1  = 1;
  localparam int PL_CFG2  = 2;
  localparam int PL_MASK  = 3;
  localparam int PL_WAKE  = 4;
  localparam int PL_ROUTE = 5;
  localparam int ADDR_STAT0 = 2 * NPLANE;
  localparam int ADDR_STAT1 = 2 * NPLANE + 1;
  localparam int ADDR_PEND  = 2 * NPLANE + 2;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;

  // Trigger decode: only the two level codes ever detect.
  function automatic logic trig_hit(input logic [2:0] code, input logic lvl);
    case (code)
      TRIG_HIGH: return lvl;
      TRIG_LOW:  return !lvl;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irq_plane.sv
module irq_plane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_en) q <= q | bits;
    else if (clr_en) q <= q & ~bits;
  end
endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else             stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_setclr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] c0,
  input  logic [W-1:0] c1,
  input  logic [W-1:0] c2,
  output logic [W-1:0] det
);
  for (genvar i = 0; i < W; i++) begin : g_src
    assign det[i] = trig_hit({c2[i], c1[i], c0[i]}, lvl[i]);
  end
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
  import irq_setclr_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int AW     = 5,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_data,
  input  logic            rd_en,
  output logic [NSRC-1:0] rd_data,
  output logic            req0_o,
  output logic            req1_o,
  output logic            wake_o
);
  logic [NSRC-1:0] plane_q [NPLANE];
  logic [NSRC-1:0] lvl_sync;
  logic [NSRC-1:0] det;
  logic [NSRC-1:0] status0, status1, wake_hits;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] rd_next;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    irq_plane #(.W(NSRC)) u_plane (
      .clk   (clk),
      .rst   (rst),
      .set_en(wr_en && (addr == AW'(2 * p))),
      .clr_en(wr_en && (addr == AW'(2 * p + 1))),
      .bits  (wr_data),
      .q     (plane_q[p])
    );
  end

  irq_sync #(.W(NSRC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(src_in), .q(lvl_sync)
  );

  irq_detect #(.W(NSRC)) u_detect (
    .lvl(lvl_sync),
    .c0 (plane_q[PL_CFG0]),
    .c1 (plane_q[PL_CFG1]),
    .c2 (plane_q[PL_CFG2]),
    .det(det)
  );

  assign mask_q    = plane_q[PL_MASK];
  assign status0   = det & mask_q & plane_q[PL_ROUTE];
  assign status1   = det & mask_q & ~plane_q[PL_ROUTE];
  assign wake_hits = det & plane_q[PL_WAKE];

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NPLANE; p++) begin
      if (addr[AW-1:1] == (AW-1)'(p)) rd_next = plane_q[p];
    end
    if (addr == AW'(ADDR_STAT0)) rd_next = status0;
    if (addr == AW'(ADDR_STAT1)) rd_next = status1;
    if (addr == AW'(ADDR_PEND))  rd_next = det;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req0_o  <= 1'b0;
      req1_o  <= 1'b0;
      wake_o  <= 1'b0;
      rd_data <= '0;
    end else begin
      req0_o <= |status0;
      req1_o <= |status1;
      wake_o <= |wake_hits;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/irq_setclr_ctrl_chk.sv
module irq_setclr_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   addr,
  input logic            wr_en,
  input logic [NSRC-1:0] wr_data,
  input logic            rd_en,
  input logic [NSRC-1:0] rd_data,
  input logic            req0_o,
  input logic            req1_o,
  input logic            wake_o,
  input logic [NSRC-1:0] status0,
  input logic [NSRC-1:0] status1,
  input logic [NSRC-1:0] wake_hits,
  input logic [NSRC-1:0] mask_q
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: outputs are quiet on the first edge after a reset cycle
  always_ff @(posedge clk) begin
    if (rst_q && !rst)
      a_r1_reset_quiet: assert (!req0_o && !req1_o && !wake_o && rd_data == '0);
  end

  a_r2_set_ors: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(6)) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

  a_r2_clr_removes: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(7)) |=> ((mask_q & $past(wr_data)) == '0));

  a_r7_masked_out: assert property (@(posedge clk) disable iff (rst)
    (((status0 | status1) & ~mask_q) == '0));

  a_r10_req0_follows: assert property (@(posedge clk) disable iff (rst)
    (|status0) |=> req0_o);

  a_r10_req1_follows: assert property (@(posedge clk) disable iff (rst)
    !(|status1) |=> !req1_o);

  a_r8_wake_follows: assert property (@(posedge clk) disable iff (rst)
    (|wake_hits) |=> wake_o);

  a_r12_rd_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind irq_setclr_ctrl irq_setclr_ctrl_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .req0_o(req0_o), .req1_o(req1_o),
  .wake_o(wake_o), .status0(status0), .status1(status1),
  .wake_hits(wake_hits), .mask_q(mask_q)
);

// File: tb/irq_setclr_ctrl_bench.sv
module irq_setclr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = 32'h0;
  logic [4:0]  addr = 5'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        req0_o, req1_o, wake_o;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_setclr_ctrl u_irq_setclr_ctrl (
    .clk(clk), .rst(rst), .src_in(src_in), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  // Behavioural reference model
  logic [31:0] m_pl [6];
  logic [31:0] m_s1, m_s2, m_rd;
  logic        m_req0, m_req1, m_wake;

  function automatic logic [31:0] m_detect();
    logic [31:0] d = 32'h0;
    for (int i = 0; i < 32; i++) begin
      int code = m_pl[2][i] * 4 + m_pl[1][i] * 2 + m_pl[0][i];
      if (code == 5) d[i] = m_s2[i];
      else if (code == 6) d[i] = !m_s2[i];
    end
    return d;
  endfunction

  always @(posedge clk) begin
    logic [31:0] d, s0, s1;
    if (rst) begin
      for (int p = 0; p < 6; p++) m_pl[p] <= 32'h0;
      m_s1 <= 0; m_s2 <= 0; m_rd <= 0;
      m_req0 <= 0; m_req1 <= 0; m_wake <= 0;
    end else begin
      d  = m_detect();
      s0 = d & m_pl[3] & m_pl[5];
      s1 = d & m_pl[3] & ~m_pl[5];
      m_s1 <= src_in;
      m_s2 <= m_s1;
      m_req0 <= (s0 != 0);
      m_req1 <= (s1 != 0);
      m_wake <= ((d & m_pl[4]) != 0);
      if (wr_en && addr < 12) begin
        if (addr % 2 == 0) m_pl[addr / 2] <= m_pl[addr / 2] | wr_data;
        else               m_pl[addr / 2] <= m_pl[addr / 2] & ~wr_data;
      end
      if (rd_en) begin
        if (addr < 12)       m_rd <= m_pl[addr / 2];
        else if (addr == 12) m_rd <= s0;
        else if (addr == 13) m_rd <= s1;
        else if (addr == 14) m_rd <= d;
        else                 m_rd <= 0;
      end
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R10, R12 and the current phase)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, "req0", {31'h0, req0_o}, {31'h0, m_req0});
      chk(tag, "req1", {31'h0, req1_o}, {31'h0, m_req1});
      chk(tag, "wake", {31'h0, wake_o}, {31'h0, m_wake});
      chk(tag, "rd_data", rd_data, m_rd);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    addr = 5'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input string t, input int a, input logic [31:0] exp);
    addr = 5'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(t, "read", rd_data, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    src_in = 32'h0000_000C;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    chk("R1", "req0", {31'h0, req0_o}, 32'h0);
    chk("R1", "wake", {31'h0, wake_o}, 32'h0);
    for (int p = 0; p < 6; p++) rd_expect("R1", 2 * p, 32'h0);

    // R2: set/clear semantics, read via clear address
    tag = "R2";
    wr(6, 32'hFF00_FF00);
    wr(7, 32'h0F00_0F00);
    rd_expect("R2", 6, 32'hF000_F000);
    rd_expect("R2", 7, 32'hF000_F000);
    wr(7, 32'hFFFF_FFFF);
    rd_expect("R2", 6, 32'h0);

    // R3/R4/R6: sources 0,1 high-active, 2,3 low-active; 0,2 to line 0
    tag = "R3";
    wr(4, 32'h0000_000F);
    wr(0, 32'h0000_0003);
    wr(2, 32'h0000_000C);
    wr(6, 32'h0000_000F);
    wr(10, 32'h0000_0005);
    settle();
    rd_expect("R3", 12, 32'h0);
    rd_expect("R3", 13, 32'h0);
    src_in = 32'h0000_000D; settle();
    rd_expect("R3", 12, 32'h1);
    chk("R3", "req0", {31'h0, req0_o}, 32'h1);
    tag = "R6";
    src_in = 32'h0000_000E; settle();
    rd_expect("R6", 13, 32'h2);
    rd_expect("R6", 12, 32'h0);
    chk("R6", "req1", {31'h0, req1_o}, 32'h1);
    chk("R6", "req0", {31'h0, req0_o}, 32'h0);
    tag = "R4";
    src_in = 32'h0000_0008; settle();
    rd_expect("R4", 12, 32'h4);
    rd_expect("R4", 13, 32'h0);
    // R11: leaving the active level clears the status
    tag = "R11";
    src_in = 32'h0000_000C; settle();
    rd_expect("R11", 12, 32'h0);
    chk("R11", "req0", {31'h0, req0_o}, 32'h0);

    // R5: codes 000 (bit 8), 111 (bit 9), 010 (bit 10) never detect
    tag = "R5";
    wr(0, 32'h0000_0200);
    wr(2, 32'h0000_0600);
    wr(4, 32'h0000_0200);
    wr(6, 32'h0000_0700);
    wr(10, 32'h0000_0700);
    src_in = 32'h0000_030C; settle();
    rd_expect("R5", 12, 32'h0);
    rd_expect("R9", 14, 32'h0);
    src_in = 32'h0000_000C; settle();
    rd_expect("R5", 14, 32'h0);
    rd_expect("R9", 15, 32'h0);

    // R7: masking a detected source removes it from status and request
    tag = "R7";
    src_in = 32'h0000_000D; settle();
    rd_expect("R7", 12, 32'h1);
    wr(7, 32'h0000_0001);
    settle();
    rd_expect("R7", 12, 32'h0);
    rd_expect("R7", 6, 32'h0000_070E);
    chk("R7", "req0", {31'h0, req0_o}, 32'h0);

    // R8: wakeup from a masked source
    tag = "R8";
    wr(8, 32'h0000_0001);
    settle();
    chk("R8", "wake", {31'h0, wake_o}, 32'h1);
    rd_expect("R8", 8, 32'h1);
    rd_expect("R9", 14, 32'h1);

    // R10: input change reaches wake_o on the third rising edge
    tag = "R10";
    src_in = 32'h0000_000C;
    @(negedge clk); chk("R10", "wake+1", {31'h0, wake_o}, 32'h1);
    @(negedge clk); chk("R10", "wake+2", {31'h0, wake_o}, 32'h1);
    @(negedge clk); chk("R10", "wake+3", {31'h0, wake_o}, 32'h0);
    // R10: a plane write reaches req0_o on the second rising edge
    src_in = 32'h0000_000D; settle();
    wr(6, 32'h0000_0001);
    chk("R10", "req0+1", {31'h0, req0_o}, 32'h0);
    @(negedge clk); chk("R10", "req0+2", {31'h0, req0_o}, 32'h1);

    // R12: rd_data holds without a read strobe
    tag = "R12";
    rd_expect("R12", 12, 32'h1);
    held = rd_data;
    src_in = 32'h0000_000C;
    wr(7, 32'hFFFF_FFFF);
    settle();
    chk("R12", "held", rd_data, held);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule